// File: doc/BRIEF.md
# Quad I/O Read Engine

This block is the flash-side controller for a four-line fast read. The host drives a one-byte opcode serially on IO0. The address and a mode byte then arrive four bits per clock on IO3..IO0, followed by dummy clocks. After that the block streams array bytes back on all four lines, high nibble first. The block works from strobes that mark SCLK rising and falling edges, already sampled into the system clock domain. It never sees SCLK as a clock.

Two features change the frame layout:
- **Continuous read mode.** A mode byte with a chosen two-bit key lets the next chip-select frame begin directly with the address, with no opcode.
- **Burst wrap.** A separate setup command selects a burst-wrap window. Sequential reads then stay inside an aligned 8, 16, 32 or 64-byte window.

**Memory port.** Array bytes come from a byte-wide memory read port with a valid/ready handshake.
- `mem_valid` rises with `mem_addr` set.
- Both hold steady until the cycle where `mem_ready` is high.
- `mem_rdata` is taken in that same cycle.
- The block has one request in flight at a time. It keeps one byte ready ahead of the SCLK falling edge that sends it out.
- The memory must finish the handshake within two SCLK periods of the request. The first request is an exception: it has the four dummy clocks to complete.
- A chip-select rise withdraws any open request.

Top module: `qrd_engine`

## Requirements
- R1: After reset the IO drivers are off, no memory request is open, and the next frame is decoded as an opcode. Burst wrap is off, so reads run linearly across aligned 8-byte boundaries.
- R2: Opcode EBh starts a quad read only while `qe` is 1. With `qe` at 0 the frame is ignored: no memory request and no driver enable.
- R3: The opcode takes 8 clocks on IO0, MSB first. Address bits 23..0 then take 6 clocks as nibbles, most significant nibble first. The mode byte takes 2 clocks, high nibble first, followed by 4 dummy clocks. The drivers stay off through all of these phases and switch on, all four together, at the first data falling edge.
- R4: Each byte goes out over two falling edges, bits 7..4 then bits 3..0, with the higher bit on IO3 and the lower on IO0. The IO outputs change only on falling edges.
- R5: With wrap off, the address steps by one after every byte. It rolls from 0FFFFFh to 000000h, and only the low 20 address bits are used.
- R6: A mode byte whose bits 5..4 are 10b makes the next frame start directly with the 6 address clocks. That frame's own mode byte again decides the frame after it.
- R7: Any other value in mode bits 5..4 returns the block to opcode decoding on the next frame.
- R8: In a frame that starts in continuous mode, holding IO0 high for 8 clocks (FFh) sets mode bit 4. This leaves continuous mode, and the following frame needs an opcode.
- R9: Opcode 77h (with `qe` = 1) is followed by 6 don't-care nibbles and a wrap byte W, high nibble first. W bit 4 = 0 turns wrap on, W bit 4 = 1 turns it off, and W bits 6..5 pick the window: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bytes.
- R10: With wrap on, reading starts at the given address. Past the last byte of its aligned window it continues at the window start, for as long as the frame lasts.
- R11: `mem_valid` and `mem_addr` hold steady until `mem_ready`. The handshake addresses follow the read order.
- R12: A high `cs_n` ends the frame: the drivers switch off and any open request is dropped within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low, synchronized |
| sclk_rise | input | 1 | One-cycle strobe: SCLK rising edge |
| sclk_fall | input | 1 | One-cycle strobe: SCLK falling edge |
| io_in | input | 4 | Sampled IO3..IO0 levels |
| qe | input | 1 | Quad operation enabled |
| io_out | output | 4 | Drive values for IO3..IO0 |
| io_oe | output | 4 | Drive enables for IO3..IO0 |
| mem_addr | output | 20 | Memory read address |
| mem_valid | output | 1 | Memory read request |
| mem_ready | input | 1 | Memory accepts request, data valid |
| mem_rdata | input | 8 | Memory read data |

## Verification
A wrong phase counter or mode key shows up at the ports within one frame. The output nibbles come from the wrong address, or the drivers switch on before or after the first data falling edge. A wrong continuous-mode flag hides until the next frame, when an opcode is taken as address nibbles or the reverse. The bench therefore always follows a mode change with one more frame. Wrap state errors appear at the first byte past a window edge, so every wrap check starts a few bytes before that edge.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_WRAP,
    PH_IDLE
  } qrd_phase_e;

  localparam logic [7:0] OP_QREAD = 8'hEB;
  localparam logic [7:0] OP_WRAP  = 8'h77;
  localparam logic [1:0] CONT_KEY = 2'b10;
endpackage

// File: rtl/qrd_addr_next.sv
module qrd_addr_next #(
  parameter int AW = 20
) (
  input  logic [AW-1:0] cur,
  input  logic          wrap_en,
  input  logic [1:0]    wrap_sz,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] mask;
  logic [AW-1:0] inc;

  always_comb begin
    inc  = cur + AW'(1);
    mask = (AW'(8) << wrap_sz) - AW'(1);
    if (wrap_en) nxt = (cur & ~mask) | (inc & mask);
    else         nxt = inc;
  end
endmodule

// File: rtl/qrd_fetch.sv
module qrd_fetch #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          pull,
  input  logic          wrap_en,
  input  logic [1:0]    wrap_sz,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    byte_q
);
  logic [AW-1:0] addr_nxt;

  qrd_addr_next #(.AW(AW)) u_next (
    .cur(mem_addr), .wrap_en(wrap_en), .wrap_sz(wrap_sz), .nxt(addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      byte_q    <= '0;
    end else if (cs_n) begin
      mem_valid <= 1'b0;
    end else begin
      if (mem_valid && mem_ready) begin
        byte_q    <= mem_rdata;
        mem_valid <= 1'b0;
        mem_addr  <= addr_nxt;
      end
      if (load) begin
        mem_addr  <= load_addr;
        mem_valid <= 1'b1;
      end else if (pull) begin
        mem_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qrd_engine.sv
module qrd_engine #(
  parameter int AW         = 20,
  parameter int DUMMY_CLKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic [3:0]    io_in,
  input  logic          qe,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_valid,
  input  logic          mem_ready,
  input  logic [7:0]    mem_rdata
);
  import qrd_pkg::*;

  localparam int ADDR_NIBS = 6;
  localparam int MODE_NIBS = 2;
  localparam logic [2:0] ADDR_LAST  = 3'(ADDR_NIBS + MODE_NIBS - 1);
  localparam logic [2:0] MODE_FIRST = 3'(ADDR_NIBS);
  localparam logic [2:0] DUMMY_LAST = 3'(DUMMY_CLKS - 1);

  qrd_phase_e    phase;
  logic [2:0]    cnt;
  logic [6:0]    cmd_sh;
  logic [AW-1:0] addr_sh;
  logic [1:0]    mode_key;
  logic [2:0]    wrap_bits;
  logic          cont_q;
  logic          wrap_en_q;
  logic [1:0]    wrap_sz_q;
  logic          nib_hi;
  logic [3:0]    lo_nib;
  logic          oe_q;
  logic [7:0]    byte_q;
  logic [7:0]    op_full;
  logic          load;
  logic          pull;

  assign op_full = {cmd_sh, io_in[0]};
  assign load    = sclk_rise && !cs_n && phase == PH_ADDR && cnt == ADDR_LAST;
  assign pull    = sclk_fall && !cs_n && phase == PH_DATA && nib_hi;
  assign io_oe   = {4{oe_q}};

  qrd_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .load(load), .load_addr(addr_sh), .pull(pull),
    .wrap_en(wrap_en_q), .wrap_sz(wrap_sz_q),
    .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .byte_q(byte_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      cnt       <= '0;
      cmd_sh    <= '0;
      addr_sh   <= '0;
      mode_key  <= '0;
      wrap_bits <= '0;
      cont_q    <= 1'b0;
      wrap_en_q <= 1'b0;
      wrap_sz_q <= '0;
      nib_hi    <= 1'b1;
      lo_nib    <= '0;
      oe_q      <= 1'b0;
      io_out    <= '0;
    end else if (cs_n) begin
      phase  <= cont_q ? PH_ADDR : PH_CMD;
      cnt    <= '0;
      nib_hi <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      if (sclk_rise) begin
        case (phase)
          PH_CMD: begin
            cmd_sh <= op_full[6:0];
            cnt    <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (qe && op_full == OP_QREAD)     phase <= PH_ADDR;
              else if (qe && op_full == OP_WRAP) phase <= PH_WRAP;
              else                               phase <= PH_IDLE;
            end
          end
          PH_ADDR: begin
            cnt <= cnt + 3'd1;
            if (cnt < MODE_FIRST)  addr_sh  <= {addr_sh[AW-5:0], io_in};
            if (cnt == MODE_FIRST) mode_key <= io_in[1:0];
            if (cnt == ADDR_LAST) begin
              cont_q <= (mode_key == CONT_KEY);
              phase  <= PH_DUMMY;
            end
          end
          PH_DUMMY: begin
            cnt <= cnt + 3'd1;
            if (cnt == DUMMY_LAST) begin
              phase <= PH_DATA;
              cnt   <= '0;
            end
          end
          PH_WRAP: begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd6) wrap_bits <= io_in[2:0];
            if (cnt == 3'd7) begin
              wrap_en_q <= ~wrap_bits[0];
              wrap_sz_q <= wrap_bits[2:1];
              phase     <= PH_IDLE;
            end
          end
          default: ;
        endcase
      end
      if (sclk_fall && phase == PH_DATA) begin
        if (nib_hi) begin
          io_out <= byte_q[7:4];
          lo_nib <= byte_q[3:0];
          oe_q   <= 1'b1;
          nib_hi <= 1'b0;
        end else begin
          io_out <= lo_nib;
          nib_hi <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qrd_engine_chk.sv
module qrd_engine_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sclk_fall,
  input logic [3:0]    io_out,
  input logic [3:0]    io_oe,
  input logic [AW-1:0] mem_addr,
  input logic          mem_valid,
  input logic          mem_ready
);
  p_oe_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (io_oe == 4'h0));

  p_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !mem_valid);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !cs_n) |=> mem_valid);

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !cs_n) |=> $stable(mem_addr));

  p_out_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(io_out));

  p_oe_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_oe[0]) |-> $past(sclk_fall));

  p_oe_uniform_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'hF));
endmodule

bind qrd_engine qrd_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_fall(sclk_fall),
  .io_out(io_out), .io_oe(io_oe), .mem_addr(mem_addr),
  .mem_valid(mem_valid), .mem_ready(mem_ready)
);

// File: tb/qrd_engine_bench.sv
module qrd_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk_rise = 1'b0;
  logic        sclk_fall = 1'b0;
  logic [3:0]  io_in = 4'h0;
  logic        qe = 1'b1;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic [19:0] mem_addr;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int fails = 0;
  int hs_n = 0;
  logic [19:0] hs_addr [0:255];

  always #5 clk = ~clk;

  qrd_engine u_qrd_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .io_in(io_in), .qe(qe), .io_out(io_out),
    .io_oe(io_oe), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] memf(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
  endfunction

  assign mem_rdata = memf(mem_addr);

  always @(posedge clk) begin
    mem_ready <= mem_valid && !mem_ready;
    if (mem_valid && mem_ready) begin
      hs_addr[hs_n[7:0]] <= mem_addr;
      hs_n <= hs_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] din, output logic [3:0] dout, output logic oe);
    @(negedge clk) sclk_fall = 1'b1;
    @(negedge clk) sclk_fall = 1'b0;
    @(negedge clk);
    dout = io_out;
    oe = io_oe[0];
    io_in = din;
    @(negedge clk) sclk_rise = 1'b1;
    @(negedge clk) sclk_rise = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame_start();
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic frame_end();
    @(negedge clk) cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(io_oe == 4'h0 && !mem_valid, "R12 deselect", {io_oe, 3'b0, mem_valid}, 0);
  endtask

  task automatic send_op(input logic [7:0] op);
    logic [3:0] d; logic o;
    for (int i = 7; i >= 0; i--) cyc({3'b000, op[i]}, d, o);
  endtask

  task automatic send_addr_mode(input logic [23:0] a, input logic [7:0] m);
    logic [3:0] d; logic o; logic seen;
    seen = 1'b0;
    for (int i = 5; i >= 0; i--) begin cyc(a[i*4 +: 4], d, o); seen |= o; end
    cyc(m[7:4], d, o); seen |= o;
    cyc(m[3:0], d, o); seen |= o;
    for (int i = 0; i < 4; i++) begin cyc(4'h0, d, o); seen |= o; end
    chk(!seen, "R3 drivers off before data", seen, 0);
  endtask

  // wsize 0 means linear
  task automatic read_bytes(input logic [19:0] start, input int n, input int wsize, input string tag);
    logic [3:0] hi, lo; logic o1, o2; logic [19:0] ea;
    for (int k = 0; k < n; k++) begin
      cyc(4'h0, hi, o1);
      cyc(4'h0, lo, o2);
      if (wsize == 0) ea = start + 20'(k);
      else ea = (start & ~20'(wsize - 1)) | ((start + 20'(k)) & 20'(wsize - 1));
      chk(o1 && o2 && {hi, lo} == memf(ea), tag, {o1, o2, hi, lo}, {2'b11, memf(ea)});
    end
  endtask

  task automatic set_wrap(input logic [7:0] w);
    logic [3:0] d; logic o;
    frame_start();
    send_op(8'h77);
    for (int i = 0; i < 6; i++) cyc(4'hF, d, o);
    cyc(w[7:4], d, o);
    cyc(w[3:0], d, o);
    frame_end();
  endtask

  task automatic t_reset();
    chk(io_oe == 4'h0, "R1 drivers off after reset", io_oe, 0);
    chk(!mem_valid, "R1 no request after reset", mem_valid, 0);
  endtask

  task automatic t_qe_gate();
    logic [3:0] d; logic o; logic seen; int h0;
    qe = 1'b0; h0 = hs_n; seen = 1'b0;
    frame_start();
    send_op(8'hEB);
    for (int i = 0; i < 16; i++) begin cyc(4'h0, d, o); seen |= o; end
    frame_end();
    chk(!seen && hs_n == h0, "R2 read ignored with qe low", {seen, 8'(hs_n - h0)}, 0);
    qe = 1'b1;
  endtask

  task automatic t_linear();
    int h0;
    h0 = hs_n;
    frame_start();
    send_op(8'hEB);
    send_addr_mode(24'hA12345, 8'h00);
    read_bytes(20'h12345, 4, 0, "R1 R4 linear read no wrap");
    frame_end();
    for (int i = 0; i < 3; i++)
      chk(hs_addr[8'(h0 + i)] == 20'h12345 + 20'(i), "R11 handshake order",
          hs_addr[8'(h0 + i)], 20'h12345 + 20'(i));
  endtask

  task automatic t_rollover();
    frame_start();
    send_op(8'hEB);
    send_addr_mode(24'h0FFFFE, 8'hF0);
    read_bytes(20'hFFFFE, 3, 0, "R5 rollover");
    frame_end();
  endtask

  task automatic t_cont();
    frame_start(); send_op(8'hEB); send_addr_mode(24'h000200, 8'h20);
    read_bytes(20'h00200, 2, 0, "R6 entry frame"); frame_end();
    frame_start(); send_addr_mode(24'h000300, 8'h20);
    read_bytes(20'h00300, 2, 0, "R6 frame without opcode"); frame_end();
    frame_start(); send_addr_mode(24'h000400, 8'h00);
    read_bytes(20'h00400, 1, 0, "R6 last continuous frame"); frame_end();
    frame_start(); send_op(8'hEB); send_addr_mode(24'h000500, 8'h00);
    read_bytes(20'h00500, 1, 0, "R7 opcode decoding back"); frame_end();
  endtask

  task automatic t_ffh();
    logic [3:0] d; logic o;
    frame_start(); send_op(8'hEB); send_addr_mode(24'h000600, 8'hA5);
    read_bytes(20'h00600, 1, 0, "R6 key 10 with other bits"); frame_end();
    frame_start();
    for (int i = 0; i < 8; i++) cyc(4'b0001, d, o);
    frame_end();
    frame_start(); send_op(8'hEB); send_addr_mode(24'h000700, 8'h00);
    read_bytes(20'h00700, 1, 0, "R8 FFh leaves continuous mode"); frame_end();
  endtask

  task automatic t_wrap_one(input logic [7:0] w, input int wsize, input logic [19:0] start, input string tag);
    set_wrap(w);
    frame_start(); send_op(8'hEB); send_addr_mode({4'h0, start}, 8'h00);
    read_bytes(start, 5, wsize, tag); frame_end();
  endtask

  task automatic t_wrap();
    t_wrap_one(8'h00, 8,  20'h02006, "R9 R10 wrap 8");
    t_wrap_one(8'h20, 16, 20'h0103D, "R9 R10 wrap 16");
    t_wrap_one(8'h4F, 32, 20'h0511E, "R9 R10 wrap 32");
    t_wrap_one(8'h60, 64, 20'h03F3E, "R9 R10 wrap 64");
    t_wrap_one(8'h70, 0,  20'h000FE, "R9 wrap off by W4");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_linear();
    t_qe_gate();
    t_rollover();
    t_cont();
    t_ffh();
    t_wrap();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule